// File: doc/BRIEF.md
# AES3 Biphase-Mark Frame Transmitter

This block turns a stream of 24-bit stereo audio samples into a serial AES3 / S/PDIF line signal. Each frame holds two 32-slot subframes: the first carries the left sample, the second the right. Every subframe starts with a synchronising preamble, followed by the audio word, then the validity, user, channel-status and parity bits. The block biphase-mark encodes the result and drives a complementary output pair. A frame counter runs alongside it and marks the start of each 192-frame channel-status block with its own preamble.

The encoder steps on a half-cell strobe `tx_tick`, which pulses 128 times per frame, inside a faster system clock. A sample presented on `smp_stb` waits in a one-entry holding stage until the next frame start takes it. If no new sample has arrived by then, the last one is sent again. If a second sample arrives before the first was taken, the first is lost. Either event raises a one-clock `slip` pulse. Further controls cover mono transmission (two consecutive samples of one channel fill one frame), muting, an output disable, selection of the user-bit source, and a restart strobe that starts a new frame and a new block.

Channel-status and user bits for a whole block arrive as parallel vectors, one bit per frame index.

Top module: `aes3_frame_tx`

## Requirements
- R1: A subframe lasts 64 ticks (32 slots of two half-cells each). Slots 0-3 carry the preamble. Slots 4-27 carry audio bits 0..23, least significant bit first. Slot 28 is V (taken from `vflag`), 29 is U, 30 is C and 31 is P. Each of slots 4-31 toggles the line at its first half-cell, and toggles again at its second half-cell only if its bit is 1. Subframe A (left) comes before subframe B (right).
- R2: P makes the count of ones over slots 4-31 even.
- R3: Preambles are defined by their line toggles over their 8 half-cells, where 1 means a toggle. B is 1,0,0,1,1,1,0,0 and starts subframe A of frame 0 of each 192-frame block. M is 1,0,0,1,0,0,1,1 and starts every other A subframe. W is 1,0,0,1,0,1,1,0 and starts every B subframe.
- R4: When `blk_sync` is high on 4 consecutive clocks, the stream restarts at frame 0, subframe A, slot 0, so the next preamble is B. A high level lasting 3 clocks changes nothing.
- R5: `txp` and `txn` are both 0 in any of three cases: `rst_n` is low, no `tx_tick` has come for 16 clocks (or none since reset), or `tx_off` is high. Otherwise `txn` is the complement of `txp`.
- R6: `mute` is sampled once per subframe, at slot 1. A muted subframe carries all-zero audio with parity recomputed, while V, U, C and the preamble are unchanged.
- R7: With `mono_en` high, two consecutive strobed samples of one channel fill one frame: the first goes to A, the second to B. `mono_right` chooses the channel, 0 for left and 1 for right.
- R8: `slip` pulses in two cases. The first is a frame start with no new sample, where the previous pair is repeated. The second is a sample arriving while one is still waiting, where the newer sample is kept.
- R9: U equals `user_ext` when `user_ext_sel` is 1, and `user_blk[frame index]` when it is 0. It is sampled at slot 1.
- R10: C equals `cs_blk[frame index]` in both subframes of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_tick | input | 1 | half-cell strobe, 128 per frame |
| smp_stb | input | 1 | new sample present |
| smp_left | input | 24 | left sample |
| smp_right | input | 24 | right sample |
| mono_en | input | 1 | mono mode enable |
| mono_right | input | 1 | mono channel select (1 = right) |
| mute | input | 1 | zero the audio bits |
| tx_off | input | 1 | force both outputs low |
| vflag | input | 1 | validity bit value |
| cs_blk | input | 192 | channel-status bit per frame index |
| user_blk | input | 192 | stored user bit per frame index |
| user_ext_sel | input | 1 | take U from `user_ext` |
| user_ext | input | 1 | external user bit |
| blk_sync | input | 1 | frame/block restart strobe |
| txp | output | 1 | line output, true polarity |
| txn | output | 1 | line output, inverted polarity |
| slip | output | 1 | sample dropped or repeated |

## Verification
The assertions watch structural properties on every cycle. The slot counter must wrap cleanly at the end of each subframe, and the frame index must stay inside the block. The line may change level only on a tick. The output may come alive only after a tick has arrived. A 4-cycle restart strobe must land on frame 0, slot 0. Only the bench can show that the encoded stream is correct, because that needs a decoder. The bench recovers preambles and 28-bit words from the line toggles. It checks payload ordering, parity, muting, mono pairing, user and channel-status selection, the slip counts and the preamble at the 192-frame wrap.

// File: rtl/aes3_frame_tx.sv
module aes3_frame_tx #(
  parameter int AUD_W        = 24,
  parameter int BLOCK_LEN    = 192,
  parameter int TICK_TIMEOUT = 16,
  parameter int SYNC_HOLD    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_tick,
  input  logic                 smp_stb,
  input  logic [AUD_W-1:0]     smp_left,
  input  logic [AUD_W-1:0]     smp_right,
  input  logic                 mono_en,
  input  logic                 mono_right,
  input  logic                 mute,
  input  logic                 tx_off,
  input  logic                 vflag,
  input  logic [BLOCK_LEN-1:0] cs_blk,
  input  logic [BLOCK_LEN-1:0] user_blk,
  input  logic                 user_ext_sel,
  input  logic                 user_ext,
  input  logic                 blk_sync,
  output logic                 txp,
  output logic                 txn,
  output logic                 slip
);
  localparam int SUB_SLOTS = AUD_W + 8;
  localparam int SW = $clog2(SUB_SLOTS);
  localparam int FW = $clog2(BLOCK_LEN);
  localparam int GW = $clog2(TICK_TIMEOUT + 1);
  localparam int CW = $clog2(SYNC_HOLD + 1);
  localparam int WW = AUD_W + 4;
  localparam logic [SW-1:0] LAST_SLOT  = SW'(SUB_SLOTS - 1);
  localparam logic [SW-1:0] FIRST_DATA = SW'(4);
  localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_LEN - 1);
  localparam logic [GW-1:0] GAP_MAX    = GW'(TICK_TIMEOUT);
  localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_HOLD - 1);
  localparam logic [CW-1:0] SYNC_SAT   = CW'(SYNC_HOLD);
  localparam logic [7:0] TOG_B = 8'h39;
  localparam logic [7:0] TOG_M = 8'hC9;
  localparam logic [7:0] TOG_W = 8'h69;

  logic [SW-1:0]    slot;
  logic             half, sub, line;
  logic [FW-1:0]    frame;
  logic [GW-1:0]    gap;
  logic [CW-1:0]    sync_cnt;
  logic [AUD_W-1:0] pend_a, pend_b, cur_a, cur_b;
  logic             pend, mono_ph;
  logic [WW-1:0]    sf_word;

  wire fire      = blk_sync && (sync_cnt == SYNC_LAST);
  wire step      = tx_tick && !fire;
  wire load      = step && !sub && (slot == '0) && !half;
  wire latch_w   = step && (slot == SW'(1)) && !half;
  wire ready_new = smp_stb && (!mono_en || mono_ph);
  wire clk_ok    = (gap != GAP_MAX);

  wire [AUD_W-1:0] mono_pick = mono_right ? smp_right : smp_left;
  wire [AUD_W-1:0] aud_raw   = sub ? cur_b : cur_a;
  wire [AUD_W-1:0] aud_out   = mute ? '0 : aud_raw;
  wire             u_bit     = user_ext_sel ? user_ext : user_blk[frame];
  wire             c_bit     = cs_blk[frame];
  wire [7:0]       pre_tog   = sub ? TOG_W : ((frame == '0) ? TOG_B : TOG_M);
  wire [SW-1:0]    dslot     = slot - FIRST_DATA;

  logic tog;
  always_comb begin
    if (slot < FIRST_DATA) tog = pre_tog[{slot[1:0], half}];
    else                   tog = !half || sf_word[dslot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0; half <= 1'b0; sub <= 1'b0; frame <= '0; line <= 1'b0;
    end else if (fire) begin
      slot <= '0; half <= 1'b0; sub <= 1'b0; frame <= '0;
    end else if (tx_tick) begin
      line <= line ^ tog;
      half <= !half;
      if (half) begin
        if (slot == LAST_SLOT) begin
          slot <= '0;
          sub  <= !sub;
          if (sub) frame <= (frame == LAST_FRAME) ? '0 : frame + FW'(1);
        end else begin
          slot <= slot + SW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= GAP_MAX; sync_cnt <= '0;
    end else begin
      if (tx_tick)            gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + GW'(1);
      if (!blk_sync)               sync_cnt <= '0;
      else if (sync_cnt != SYNC_SAT) sync_cnt <= sync_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= '0; pend_b <= '0; cur_a <= '0; cur_b <= '0;
      pend <= 1'b0; mono_ph <= 1'b0; slip <= 1'b0; sf_word <= '0;
    end else begin
      if (smp_stb) begin
        if (!mono_en)     begin pend_a <= smp_left; pend_b <= smp_right; end
        else if (!mono_ph) pend_a <= mono_pick;
        else               pend_b <= mono_pick;
      end
      mono_ph <= mono_en && (smp_stb ? !mono_ph : mono_ph);
      if (ready_new) pend <= 1'b1;
      else if (load) pend <= 1'b0;
      if (load && pend) begin cur_a <= pend_a; cur_b <= pend_b; end
      slip <= (load && !pend) || (ready_new && pend && !load);
      if (latch_w) sf_word <= {^{aud_out, vflag, u_bit, c_bit}, c_bit, u_bit, vflag, aud_out};
    end
  end

  assign txp = rst_n && clk_ok && !tx_off && line;
  assign txn = rst_n && clk_ok && !tx_off && !line;

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && half && slot == LAST_SLOT) |=> (slot == '0 && !half));
  assert_line_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_tick |=> $stable(line));
  assert_frame_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame <= LAST_FRAME);
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_sync && sync_cnt == SYNC_LAST) |=> (slot == '0 && !half && !sub && frame == '0));
  assert_alive_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ok) |-> $past(tx_tick));
endmodule

// File: tb/tb_aes3_frame_tx.sv
module tb_aes3_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int BL = 192;
  localparam logic [49:0] VEC [0:7] = '{
    {24'h000001, 24'h800000, 1'b0, 1'b0},
    {24'hFFFFFF, 24'h000000, 1'b0, 1'b0},
    {24'hA5A5A5, 24'h5A5A5A, 1'b1, 1'b0},
    {24'h123456, 24'hFEDCBA, 1'b0, 1'b0},
    {24'h7FFFFF, 24'h000003, 1'b0, 1'b1},
    {24'h0F0F0F, 24'hF0F0F0, 1'b1, 1'b1},
    {24'h000000, 24'hFFFFFE, 1'b0, 1'b0},
    {24'hC00001, 24'h300007, 1'b1, 1'b0}};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, tx_tick = 1'b0, smp_stb = 1'b0;
  logic [AW-1:0] smp_left = '0, smp_right = '0;
  logic mono_en = 1'b0, mono_right = 1'b0, mute = 1'b0, tx_off = 1'b0, vflag = 1'b0;
  logic [BL-1:0] cs_blk, user_blk;
  logic user_ext_sel = 1'b0, user_ext = 1'b0, blk_sync = 1'b0;
  logic txp, txn, slip;

  aes3_frame_tx dut (.clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .smp_stb(smp_stb),
    .smp_left(smp_left), .smp_right(smp_right), .mono_en(mono_en), .mono_right(mono_right),
    .mute(mute), .tx_off(tx_off), .vflag(vflag), .cs_blk(cs_blk), .user_blk(user_blk),
    .user_ext_sel(user_ext_sel), .user_ext(user_ext), .blk_sync(blk_sync),
    .txp(txp), .txn(txn), .slip(slip));

  int n_chk = 0, n_bad = 0, tcount = 0, slip_cnt = 0;
  bit tick_run = 1'b0;
  logic prev_lvl = 1'b0;
  logic [63:0] togs = '0;
  logic [1:0]  dec_pre  [0:511];
  logic [27:0] dec_word [0:511];
  bit          dec_cell [0:511];

  function automatic logic cs_bit(input int k);   return (k % 3) == 0; endfunction
  function automatic logic usr_bit(input int k);  return (k % 5) == 1; endfunction
  function automatic logic [1:0] pcode(input int s);
    return (s % 2 == 1) ? 2'd2 : (((s / 2) % BL == 0) ? 2'd0 : 2'd1);
  endfunction
  function automatic logic [27:0] ew(input logic [23:0] a, input logic v, u, c, m);
    logic [23:0] x = m ? 24'h0 : a;
    return {^{x, v, u, c}, c, u, v, x};
  endfunction

  initial begin
    for (int k = 0; k < BL; k++) begin cs_blk[k] = cs_bit(k); user_blk[k] = usr_bit(k); end
  end

  // tick generator and line decoder in one process
  initial begin
    forever begin
      @(negedge clk);
      if (tx_tick) begin
        int p;
        p = tcount % 64;
        togs[p] = txp ^ prev_lvl;
        prev_lvl = txp;
        if (p == 63 && tcount / 64 < 512) begin
          int s;
          s = tcount / 64;
          case (togs[7:0])
            8'h39: dec_pre[s] = 2'd0;
            8'hC9: dec_pre[s] = 2'd1;
            8'h69: dec_pre[s] = 2'd2;
            default: dec_pre[s] = 2'd3;
          endcase
          dec_cell[s] = 1'b1;
          for (int d = 0; d < 28; d++) begin
            dec_word[s][d] = togs[9 + 2*d];
            if (!togs[8 + 2*d]) dec_cell[s] = 1'b0;
          end
        end
        tcount++;
      end
      if (slip) slip_cnt++;
      tx_tick = tick_run && !tx_tick;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (tcount < n) @(posedge clk);
  endtask

  task automatic send(input logic [23:0] l, r);
    @(negedge clk); smp_left = l; smp_right = r; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  task automatic set_run(input bit on);
    @(posedge clk); tick_run = on;
  endtask

  task automatic chk_frame(input int f, input logic [27:0] ea, eb, input string tag);
    chk(dec_word[2*f] == ea, {tag, " subframe A word"}, dec_word[2*f], ea);
    chk(dec_word[2*f+1] == eb, {tag, " subframe B word"}, dec_word[2*f+1], eb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", tcount, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0, t0, k;
    bit ok;
    repeat (3) @(negedge clk);
    chk(!txp && !txn && !slip, "R5 outputs low in reset", {txp, txn, slip}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!txp && !txn, "R5 outputs low before first tick", {txp, txn}, 0);
    set_run(1'b1);

    // stereo table
    for (int i = 0; i < 8; i++) begin
      wait_to(128*(i+1) - 32);
      @(negedge clk);
      vflag = VEC[i][1]; mute = VEC[i][0];
      send(VEC[i][49:26], VEC[i][25:2]);
    end
    wait_to(128*9 - 8);
    chk(slip_cnt == 1, "R8 repeat slip at first frame only", slip_cnt, 1);
    wait_to(128*9 + 4);
    chk(dec_pre[0] == 2'd0, "R3 block start preamble B", dec_pre[0], 0);
    for (int i = 0; i < 8; i++) begin
      int f;
      f = i + 1;
      chk_frame(f, ew(VEC[i][49:26], VEC[i][1], usr_bit(f), cs_bit(f), VEC[i][0]),
                   ew(VEC[i][25:2],  VEC[i][1], usr_bit(f), cs_bit(f), VEC[i][0]),
                VEC[i][0] ? "R6 R10 muted frame" : "R1 R10 stereo frame");
      chk(dec_pre[2*f] == 2'd1 && dec_pre[2*f+1] == 2'd2, "R3 M then W",
          {dec_pre[2*f], dec_pre[2*f+1]}, 6);
      chk(dec_cell[2*f] && dec_cell[2*f+1], "R1 slot start toggles", 0, 1);
      chk(^dec_word[2*f] == 1'b0 && ^dec_word[2*f+1] == 1'b0, "R2 even parity",
          {^dec_word[2*f], ^dec_word[2*f+1]}, 0);
    end

    // user source select
    wait_to(128*10 - 32); @(negedge clk); user_ext_sel = 1'b1; user_ext = 1'b1;
    wait_to(128*11 - 32); @(negedge clk); user_ext = 1'b0;
    wait_to(128*12 - 32); @(negedge clk); user_ext_sel = 1'b0;
    wait_to(128*12 + 4);
    chk_frame(10, ew(24'hC00001, 1, 1, cs_bit(10), 0), ew(24'h300007, 1, 1, cs_bit(10), 0),
              "R9 external user bit 1");
    chk_frame(11, ew(24'hC00001, 1, 0, cs_bit(11), 0), ew(24'h300007, 1, 0, cs_bit(11), 0),
              "R9 external user bit 0");

    // mono
    wait_to(128*13 - 48); @(negedge clk); mono_en = 1'b1; mono_right = 1'b0;
    send(24'h111111, 24'h999999); send(24'h222222, 24'hAAAAAA);
    wait_to(128*14 - 56); @(negedge clk); mono_right = 1'b1;
    send(24'h333333, 24'hBBBBBB); send(24'h444444, 24'hCCCCCC);
    wait_to(128*15 - 60); @(negedge clk); mono_en = 1'b0;
    wait_to(128*15 + 4);
    chk_frame(13, ew(24'h111111, 1, usr_bit(13), cs_bit(13), 0),
                  ew(24'h222222, 1, usr_bit(13), cs_bit(13), 0), "R7 mono left pair");
    chk_frame(14, ew(24'hBBBBBB, 1, usr_bit(14), cs_bit(14), 0),
                  ew(24'hCCCCCC, 1, usr_bit(14), cs_bit(14), 0), "R7 mono right pair");

    // slips
    wait_to(128*16 + 8); s0 = slip_cnt;
    wait_to(128*17 - 48);
    send(24'h0AAAAA, 24'h0BBBBB); send(24'h0CCCCC, 24'h0DDDDD);
    wait_to(128*17 + 8);
    chk(slip_cnt - s0 == 1, "R8 drop slip", slip_cnt - s0, 1);
    wait_to(128*18 + 8);
    chk(slip_cnt - s0 == 2, "R8 repeat slip", slip_cnt - s0, 2);
    wait_to(128*19 + 4);
    chk(dec_word[34][23:0] == 24'h0CCCCC, "R8 newest sample kept", dec_word[34][23:0], 24'h0CCCCC);
    chk(dec_word[36][23:0] == 24'h0CCCCC && dec_word[37][23:0] == 24'h0DDDDD,
        "R8 repeated pair", dec_word[37][23:0], 24'h0DDDDD);

    // block wrap
    wait_to(128*193 + 70);
    chk(dec_pre[382] == 2'd1, "R3 last frame uses M", dec_pre[382], 1);
    chk(dec_pre[384] == 2'd0 && dec_pre[385] == 2'd2, "R3 B at frame 192", dec_pre[384], 0);
    chk(dec_pre[386] == 2'd1, "R3 M after block start", dec_pre[386], 1);
    chk(dec_word[384][26] == 1'b1 && dec_word[386][26] == 1'b0, "R10 C bit follows frame index",
        {dec_word[384][26], dec_word[386][26]}, 2);
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (txn !== ~txp) ok = 1'b0; end
    chk(ok, "R5 complementary outputs", ok, 1);

    // short strobe: no restart
    wait_to(128*194 + 20);
    set_run(1'b0);
    repeat (2) @(posedge clk); t0 = tcount;
    @(negedge clk); blk_sync = 1'b1;
    repeat (3) @(negedge clk); blk_sync = 1'b0;
    repeat (2) @(posedge clk);
    set_run(1'b1);
    k = (t0 + 63) / 64;
    wait_to(64*k + 128 + 4);
    chk(dec_pre[k] == pcode(k) && dec_pre[k+1] == pcode(k+1) && dec_cell[k],
        "R4 three-cycle strobe ignored", dec_pre[k], pcode(k));

    // long strobe: restart
    wait_to(128*196 + 40);
    set_run(1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); blk_sync = 1'b1;
    repeat (5) @(negedge clk); blk_sync = 1'b0; tcount = 0;
    set_run(1'b1);
    wait_to(128*2 + 4);
    chk(dec_pre[0] == 2'd0 && dec_pre[1] == 2'd2, "R4 restart begins with B", dec_pre[0], 0);
    chk(dec_pre[2] == 2'd1 && dec_pre[3] == 2'd2, "R4 frame 1 after restart", dec_pre[2], 1);
    chk(dec_word[0][26] == 1'b1 && dec_word[2][26] == 1'b0, "R10 C bits restart at index 0",
        {dec_word[0][26], dec_word[2][26]}, 2);

    // missing tick source
    set_run(1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!txp && !txn, "R5 outputs low without ticks", {txp, txn}, 0);
    set_run(1'b1);
    repeat (10) @(negedge clk);
    chk(txn === ~txp, "R5 outputs return after ticks", {txp, txn}, {txp, ~txp});

    // output disable
    @(negedge clk); tx_off = 1'b1;
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (txp || txn) ok = 1'b0; end
    chk(ok, "R5 outputs low while disabled", ok, 1);
    tx_off = 1'b0;
    @(negedge clk);
    chk(txn === ~txp, "R5 outputs after enable", {txp, txn}, {txp, ~txp});

    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(!txp && !txn, "R5 outputs low on reset", {txp, txn}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule